// File: doc/BRIEF.md
# SPI Slave Receiver with Select Gating

This block receives serial characters as an SPI slave and, in the same pass, shifts a transmit word back out. The serial clock, the data input and the active-low select are brought into the system clock domain through two-flop synchronisers. Their edges are detected there, so the system clock must run at least four times faster than the serial clock. Data is captured on each rising serial clock edge, most significant bit first. The reply bit changes on each falling edge.

Reception happens only while the select is active. While it is high, the bit counter is held at zero and no serial edge can shift a bit in. When the select drops in the middle of a character, the partial bits are lost. A software reset input clears the bit counter and both status flags, so the slave can regain framing with a master it has fallen out of step with. The character length is chosen at run time from 1 to 16 bits. Each complete character is placed, right-justified, in a receive buffer.

Top module: `spi_sel_rx`

## Requirements
- R1: For any `char_len` from 1 to 16, after `char_len` rising serial clock edges with select low, `rx_buf` holds the received bits, first bit most significant, right-justified, with all higher bits zero.
- R2: `done` rises in the same cycle that `rx_buf` is loaded. A one-cycle `rx_rd` pulse clears `done`.
- R3: When a character completes while `done` is still set, `ovr` is set. `ovr` stays set, whatever `rx_rd` does, until `ovr_clr` is pulsed or `sw_rst` is asserted. `rx_buf` then holds the newer character.
- R4: While `cs_n` is high, serial clock and data activity does not set `done` and does not advance the bit counter. The next framed character is received intact.
- R5: When `cs_n` rises partway through a character, the partial bits are discarded. The following character is framed from its first bit.
- R6: Asserting `sw_rst` clears `done`, `ovr` and the bit counter. The first rising serial clock edge after release, with select low, is taken as bit zero of a new character.
- R7: While `cs_n` is low, `miso` presents bit `char_len-1` of `tx_word` before the first edge. It then moves one bit lower on each falling edge. While `cs_n` is high, `miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Software reset, active high: clears framing and flags |
| char_len | input | 5 | Bits per character, 1 to 16 (0 or above 16 means 16) |
| sclk | input | 1 | Serial clock from the master, idle low |
| cs_n | input | 1 | Slave select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| tx_word | input | 16 | Word returned to the master |
| rx_buf | output | 16 | Last complete character, right-justified |
| done | output | 1 | Character-complete flag |
| ovr | output | 1 | Overrun flag |
| rx_rd | input | 1 | Receive buffer read strobe; clears `done` |
| ovr_clr | input | 1 | Write-one-to-clear strobe for `ovr` |

## Verification
The assertions check the following on every cycle:
- the buffer changes only together with `done`;
- `done` falls only after a read or a software reset;
- `ovr` rises only when `done` was already set;
- `ovr` falls only after a clear or a software reset;
- both flags are zero after a software reset;
- `miso` is zero, and `done` stays low, once the select has been high long enough to pass the synchroniser.

The bench's scenarios are needed to show the rest:
- correct data framing at every character length;
- the returned bit order;
- discarding of a partial character;
- the restart of framing after a software reset.

// File: rtl/spi_sel_rx.sv
module spi_sel_rx #(
  parameter int MAX_BITS = 16,
  localparam int CW = $clog2(MAX_BITS + 1),
  localparam int IW = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_rst,
  input  logic [CW-1:0]       char_len,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                mosi,
  output logic                miso,
  input  logic [MAX_BITS-1:0] tx_word,
  output logic [MAX_BITS-1:0] rx_buf,
  output logic                done,
  output logic                ovr,
  input  logic                rx_rd,
  input  logic                ovr_clr
);

  logic [2:0] sck_q;
  logic [1:0] dat_q;
  logic [1:0] sel_q;
  logic [IW-1:0] cnt, tx_idx, last;
  logic [CW-1:0] len_eff;
  logic [MAX_BITS-1:0] sh, mask, nxt;
  logic rise, fall, selected, active, done_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      dat_q <= '0;
      sel_q <= '1;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      dat_q <= {dat_q[0], mosi};
      sel_q <= {sel_q[0], cs_n};
    end

  assign rise     = sck_q[1] & ~sck_q[2];
  assign fall     = ~sck_q[1] & sck_q[2];
  assign selected = ~sel_q[1];
  assign active   = selected & ~sw_rst;

  assign len_eff = (char_len == '0 || char_len > CW'(MAX_BITS)) ? CW'(MAX_BITS) : char_len;
  assign last    = IW'(len_eff - CW'(1));

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    assign mask[i] = (i < int'(len_eff));
  end

  assign nxt      = {sh[MAX_BITS-2:0], dat_q[1]} & mask;
  assign done_set = active & rise & (cnt == last);
  assign miso     = selected ? tx_word[tx_idx] : 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      sh     <= '0;
      tx_idx <= '0;
      rx_buf <= '0;
      done   <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (!active) begin
        cnt    <= '0;
        tx_idx <= last;
      end else if (rise) begin
        sh  <= {sh[MAX_BITS-2:0], dat_q[1]};
        cnt <= done_set ? '0 : cnt + IW'(1);
      end else if (fall) begin
        tx_idx <= last - cnt;
      end

      if (done_set) rx_buf <= nxt;

      if (sw_rst) begin
        done <= 1'b0;
        ovr  <= 1'b0;
      end else begin
        if (done_set)   done <= 1'b1;
        else if (rx_rd) done <= 1'b0;
        if (done_set && done && !rx_rd) ovr <= 1'b1;
        else if (ovr_clr)               ovr <= 1'b0;
      end
    end

endmodule

// File: rtl/spi_sel_rx_chk.sv
module spi_sel_rx_chk #(
  parameter int MAX_BITS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sw_rst,
  input logic                cs_n,
  input logic                rx_rd,
  input logic                ovr_clr,
  input logic                miso,
  input logic [MAX_BITS-1:0] rx_buf,
  input logic                done,
  input logic                ovr
);

  a_r2_buf_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_buf) |-> done);

  a_r2_done_falls_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> ($past(rx_rd) || $past(sw_rst)));

  a_r3_ovr_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(done));

  a_r3_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> ($past(ovr_clr) || $past(sw_rst)));

  a_r6_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_rst) |-> (!done && !ovr));

  a_r7_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

  a_r4_no_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !$rose(done));

endmodule

bind spi_sel_rx spi_sel_rx_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cs_n(cs_n), .rx_rd(rx_rd),
  .ovr_clr(ovr_clr), .miso(miso), .rx_buf(rx_buf), .done(done), .ovr(ovr)
);

// File: tb/test_spi_sel_rx.sv
module test_spi_sel_rx;
  logic clk = 0, rst_n = 0, sw_rst = 0;
  logic [4:0] char_len = 5'd8;
  logic sclk = 0, cs_n = 1, mosi = 0, rx_rd = 0, ovr_clr = 0;
  logic [15:0] tx_word = '0;
  logic miso, done, ovr;
  logic [15:0] rx_buf;
  int runs = 0, fails = 0;

  always #4 clk = ~clk;

  spi_sel_rx i_spi_sel_rx (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .char_len(char_len),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .tx_word(tx_word),
    .rx_buf(rx_buf), .done(done), .ovr(ovr), .rx_rd(rx_rd), .ovr_clr(ovr_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift(input int n, input logic [15:0] d, output logic [15:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      mosi = d[n-1-i];
      wt(5);
      got[n-1-i] = miso;
      sclk = 1;
      wt(5);
      sclk = 0;
    end
    wt(6);
  endtask

  task automatic pulse_rd();
    rx_rd = 1; wt(1); rx_rd = 0; wt(1);
  endtask

  task automatic frame(input int n, input logic [15:0] d, output logic [15:0] got);
    char_len = 5'(n);
    cs_n = 0; wt(5);
    shift(n, d, got);
    cs_n = 1; wt(5);
  endtask

  function automatic logic [15:0] msk(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'd1 << n) - 1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [15:0] got, d;
    wt(3); rst_n = 1; wt(3);
    chk("R2 reset done", done, 0);
    chk("R3 reset ovr", ovr, 0);
    chk("R1 reset rx_buf", rx_buf, 0);
    chk("R7 miso idle deselected", miso, 0);

    for (int n = 1; n <= 16; n++) begin
      for (int p = 0; p < 3; p++) begin
        d = (p == 0) ? 16'hFFFF : (p == 1) ? (16'hA5C3 ^ 16'(n * 16'h1111)) : 16'(n * 13 + 7);
        d = d & msk(n);
        tx_word = ~d;
        frame(n, d, got);
        chk("R1 rx data", rx_buf, d);
        chk("R2 done set", done, 1);
        chk("R7 miso word", got, ~d & msk(n));
        chk("R7 miso deselected", miso, 0);
        pulse_rd();
        chk("R2 done cleared", done, 0);
      end
    end

    tx_word = 16'h0;
    frame(8, 16'h11, got);
    frame(8, 16'h22, got);
    chk("R3 ovr set", ovr, 1);
    chk("R3 newer data", rx_buf, 16'h22);
    pulse_rd();
    chk("R3 ovr kept after read", ovr, 1);
    ovr_clr = 1; wt(1); ovr_clr = 0; wt(1);
    chk("R3 ovr cleared", ovr, 0);

    mosi = 1;
    for (int i = 0; i < 5; i++) begin
      sclk = 1; wt(5); sclk = 0; wt(5);
    end
    chk("R4 no done deselected", done, 0);
    frame(8, 16'h3C, got);
    chk("R4 next char intact", rx_buf, 16'h3C);
    pulse_rd();

    char_len = 5'd8;
    cs_n = 0; wt(5);
    shift(3, 16'h7, got);
    cs_n = 1; wt(5);
    chk("R5 partial gives no done", done, 0);
    frame(8, 16'h5A, got);
    chk("R5 reframed char", rx_buf, 16'h5A);
    frame(8, 16'h5B, got);
    chk("R6 ovr before soft reset", ovr, 1);

    cs_n = 0; wt(5);
    shift(3, 16'h5, got);
    sw_rst = 1; wt(3);
    chk("R6 done cleared", done, 0);
    chk("R6 ovr cleared", ovr, 0);
    sw_rst = 0; wt(3);
    shift(8, 16'h96, got);
    chk("R6 framing restarted", rx_buf, 16'h96);
    chk("R6 done after restart", done, 1);
    cs_n = 1; wt(5);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule